// File: doc/BRIEF.md
# Byte-Packing Boot DMA Engine

This engine copies blocks between a byte-wide external memory and a word-wide internal memory. In the load direction it fetches bytes in order, gathers two of them into a 16-bit word with the earlier byte in the upper half, and writes that word into internal memory in a single cycle. In the store direction it reads one internal word in a single cycle and sends its two bytes out, upper byte first. The internal port carries an overlay page number, and every word of a transfer lands in the page that was picked at launch.

Software launches a transfer with a one-cycle `start` pulse. The pulse carries the external byte address, the internal word address, the word count, a wait-state count of 0 to 7, the overlay page and a context-reset bit. The external bus is shared with the processor core, and the core has priority. A byte access begins only in a cycle that follows one in which the core was not requesting the bus. Once begun, an access runs to its end. With context reset selected, the core is stalled for the whole transfer and gets a restart pulse at the end, so it starts again at address 0. Otherwise the core keeps running alongside the transfer.

Top module: `bytepack_dma`

## Requirements
- R1: In load mode (`cfg_dir`=0), each pair of consecutive external bytes becomes one internal word. The earlier byte goes in bits 15..8. Each word is written with exactly one `int_we` cycle.
- R2: In store mode (`cfg_dir`=1), each internal word is read with exactly one `int_re` cycle. The read data is expected on `int_rdata` in the cycle after `int_re`. Bits 15..8 of the word are written to the external bus first, then bits 7..0.
- R3: Each byte access raises the external byte address by one. Each word raises the internal word address by one. A transfer moves exactly `cfg_count` words, so it makes exactly twice that many byte accesses.
- R4: A byte strobe (`ext_rd` or `ext_wr`) stays high without a break for exactly 1 + `cfg_waits` cycles, for any `cfg_waits` from 0 to 7.
- R5: A byte access begins only at a clock edge where `core_ext_req` was low. A core request that arrives after an access has begun does not cut that access short.
- R6: With `cfg_ctx_reset`=0, `core_hold` stays low and `core_restart` never pulses.
- R7: With `cfg_ctx_reset`=1, `core_hold` is high during every memory access of the transfer. `core_restart` pulses for one cycle, in the same cycle as `done`.
- R8: When the last word has moved, `done` pulses high for exactly one cycle. After that pulse `core_hold` is low.
- R9: Every internal access of a transfer carries the launch value of `cfg_ovl` on `int_ovl`.
- R10: A start naming overlay page 1 or 2 sets `err` high for one cycle, in the cycle after the start. Such a start makes no external or internal access and raises no `done`.
- R11: A start with `cfg_count`=0 makes no memory access and gives one `done` pulse.
- R12: A `start` that arrives while a transfer is running is ignored, even one that carries an illegal overlay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released |
| start | input | 1 | One-cycle launch pulse, sampled with the configuration |
| cfg_dir | input | 1 | 0 = external to internal (load), 1 = internal to external (store) |
| cfg_ext_addr | input | EXT_AW | First external byte address |
| cfg_int_addr | input | INT_AW | First internal word address |
| cfg_count | input | CNT_W | Number of words |
| cfg_waits | input | 3 | Extra wait cycles per byte access |
| cfg_ovl | input | OVL_W | Internal overlay page |
| cfg_ctx_reset | input | 1 | Stall the core and restart it at the end |
| core_ext_req | input | 1 | Core wants the external bus |
| ext_addr | output | EXT_AW | External byte address |
| ext_rd | output | 1 | External byte read strobe |
| ext_wr | output | 1 | External byte write strobe |
| ext_wdata | output | BYTE_W | External write byte |
| ext_rdata | input | BYTE_W | External read byte |
| int_addr | output | INT_AW | Internal word address |
| int_ovl | output | OVL_W | Internal overlay page |
| int_we | output | 1 | Internal word write |
| int_re | output | 1 | Internal word read |
| int_wdata | output | WORD_W | Internal write word |
| int_rdata | input | WORD_W | Internal read word, one cycle after `int_re` |
| core_hold | output | 1 | Core stall |
| core_restart | output | 1 | Core restart-at-zero pulse |
| done | output | 1 | Transfer-complete pulse |
| err | output | 1 | Illegal-overlay rejection pulse |

## Verification
Loads and stores are run with wait counts of 0, 1, 2, 3 and 7 and with different word counts and overlay pages. A byte-order error therefore shows up as swapped halves, an address error as shifted words, and a wait-state error as a wrong strobe length. The same loads and stores are run again while a pseudo-random core request fights for the bus. This shows whether the core is given priority without an access being cut short or a byte being lost. Runs with context reset on and off show the stall and restart behaviour apart from the normal completion pulse. Illegal overlay pages, a zero count and a launch made in the middle of a transfer cover the rejected and ignored starts.

// File: rtl/bytepack_dma_pkg.sv
package bytepack_dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BYTE,
    ST_MOVE,
    ST_CAPT,
    ST_FIN
  } dma_state_e;

  typedef enum logic {
    DIR_LOAD  = 1'b0,
    DIR_STORE = 1'b1
  } dma_dir_e;

  localparam int WAIT_W = 3;

endpackage

// File: rtl/bytepack_dma_extport.sv
module bytepack_dma_extport
  import bytepack_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              core_req,
  input  logic [WAIT_W-1:0] waits,
  output logic              active,
  output logic              last
);

  logic              acc_q, acc_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              launch;

  assign launch = req && !acc_q && !core_req;
  assign last   = acc_q && (cnt_q == '0);
  assign active = acc_q;

  always_comb begin
    acc_d = acc_q;
    cnt_d = cnt_q;
    if (launch) begin
      acc_d = 1'b1;
      cnt_d = waits;
    end else if (last) begin
      acc_d = 1'b0;
    end else if (acc_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  AST_NO_START_UNDER_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_q) |-> !$past(core_req)); // R5

  AST_STROBE_UNBROKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q && !last) |=> acc_q); // R4

endmodule

// File: rtl/bytepack_dma_packer.sv
module bytepack_dma_packer #(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_word,
  input  logic              shift_byte,
  input  logic [WORD_W-1:0] word_in,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [WORD_W-1:0] word_out,
  output logic [BYTE_W-1:0] byte_out
);

  logic [WORD_W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (load_word) begin
      word_d = word_in;
    end else if (shift_byte) begin
      word_d = {word_q[WORD_W-BYTE_W-1:0], byte_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (load_word || shift_byte) begin
      word_q <= word_d;
    end
  end

  assign word_out = word_q;
  assign byte_out = word_q[WORD_W-1 -: BYTE_W];

endmodule

// File: rtl/bytepack_dma_ctrl.sv
module bytepack_dma_ctrl
  import bytepack_dma_pkg::*;
#(
  parameter int EXT_AW = 14,
  parameter int INT_AW = 10,
  parameter int CNT_W  = 10,
  parameter int OVL_W  = 3,
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cfg_dir,
  input  logic [EXT_AW-1:0] cfg_ext_addr,
  input  logic [INT_AW-1:0] cfg_int_addr,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [WAIT_W-1:0] cfg_waits,
  input  logic [OVL_W-1:0]  cfg_ovl,
  input  logic              cfg_ctx_reset,
  input  logic              byte_last,
  output logic              byte_req,
  output logic              dir_store,
  output logic [WAIT_W-1:0] waits,
  output logic              load_word,
  output logic              shift_byte,
  output logic [EXT_AW-1:0] ext_addr,
  output logic [INT_AW-1:0] int_addr,
  output logic [OVL_W-1:0]  int_ovl,
  output logic              int_we,
  output logic              int_re,
  output logic              ctx_mode,
  output logic              core_hold,
  output logic              core_restart,
  output logic              done,
  output logic              err
);

  localparam int LANES  = WORD_W / BYTE_W;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [LANE_W-1:0] LANE_LAST = LANE_W'(LANES - 1);

  dma_state_e        state_q, state_d;
  dma_dir_e          dir_q;
  logic              ctx_q;
  logic [WAIT_W-1:0] waits_q;
  logic [OVL_W-1:0]  ovl_q;
  logic [EXT_AW-1:0] eaddr_q, eaddr_d;
  logic [INT_AW-1:0] iaddr_q, iaddr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic              err_q, err_d;
  logic              ovl_bad, cfg_en;

  assign ovl_bad = (cfg_ovl == OVL_W'(1)) || (cfg_ovl == OVL_W'(2));
  assign cfg_en  = (state_q == ST_IDLE) && start && !ovl_bad;

  always_comb begin
    state_d = state_q;
    eaddr_d = eaddr_q;
    iaddr_d = iaddr_q;
    cnt_d   = cnt_q;
    lane_d  = lane_q;
    err_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start && ovl_bad) begin
          err_d = 1'b1;
        end else if (start) begin
          eaddr_d = cfg_ext_addr;
          iaddr_d = cfg_int_addr;
          cnt_d   = cfg_count;
          lane_d  = '0;
          if (cfg_count == '0)             state_d = ST_FIN;
          else if (cfg_dir == DIR_STORE)   state_d = ST_MOVE;
          else                             state_d = ST_BYTE;
        end
      end
      ST_BYTE: begin
        if (byte_last) begin
          eaddr_d = eaddr_q + 1'b1;
          if (lane_q == LANE_LAST) begin
            lane_d = '0;
            if (dir_q == DIR_LOAD)   state_d = ST_MOVE;
            else if (cnt_q == '0)    state_d = ST_FIN;
            else                     state_d = ST_MOVE;
          end else begin
            lane_d = lane_q + 1'b1;
          end
        end
      end
      ST_MOVE: begin
        iaddr_d = iaddr_q + 1'b1;
        cnt_d   = cnt_q - 1'b1;
        if (dir_q == DIR_STORE)          state_d = ST_CAPT;
        else if (cnt_q == CNT_W'(1))     state_d = ST_FIN;
        else                             state_d = ST_BYTE;
      end
      ST_CAPT: state_d = ST_BYTE;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      eaddr_q <= '0;
      iaddr_q <= '0;
      cnt_q   <= '0;
      lane_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      eaddr_q <= eaddr_d;
      iaddr_q <= iaddr_d;
      cnt_q   <= cnt_d;
      lane_q  <= lane_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= DIR_LOAD;
      ctx_q   <= 1'b0;
      waits_q <= '0;
      ovl_q   <= '0;
    end else if (cfg_en) begin
      dir_q   <= dma_dir_e'(cfg_dir);
      ctx_q   <= cfg_ctx_reset;
      waits_q <= cfg_waits;
      ovl_q   <= cfg_ovl;
    end
  end

  assign byte_req     = (state_q == ST_BYTE);
  assign dir_store    = (dir_q == DIR_STORE);
  assign waits        = waits_q;
  assign load_word    = (state_q == ST_CAPT);
  assign shift_byte   = (state_q == ST_BYTE) && byte_last;
  assign ext_addr     = eaddr_q;
  assign int_addr     = iaddr_q;
  assign int_ovl      = ovl_q;
  assign int_we       = (state_q == ST_MOVE) && (dir_q == DIR_LOAD);
  assign int_re       = (state_q == ST_MOVE) && (dir_q == DIR_STORE);
  assign ctx_mode     = ctx_q;
  assign core_hold    = ctx_q && (state_q != ST_IDLE) && (state_q != ST_FIN);
  assign done         = (state_q == ST_FIN);
  assign core_restart = done && ctx_q;
  assign err          = err_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_RESTART_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    core_restart |-> done); // R7

  AST_ERR_NO_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (state_q == ST_IDLE)); // R10

  AST_MOVE_HAS_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MOVE) |-> (cnt_q != '0)); // R3

endmodule

// File: rtl/bytepack_dma.sv
module bytepack_dma
  import bytepack_dma_pkg::*;
#(
  parameter int EXT_AW = 14,
  parameter int INT_AW = 10,
  parameter int CNT_W  = 10,
  parameter int OVL_W  = 3,
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cfg_dir,
  input  logic [EXT_AW-1:0] cfg_ext_addr,
  input  logic [INT_AW-1:0] cfg_int_addr,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [2:0]        cfg_waits,
  input  logic [OVL_W-1:0]  cfg_ovl,
  input  logic              cfg_ctx_reset,
  input  logic              core_ext_req,
  output logic [EXT_AW-1:0] ext_addr,
  output logic              ext_rd,
  output logic              ext_wr,
  output logic [BYTE_W-1:0] ext_wdata,
  input  logic [BYTE_W-1:0] ext_rdata,
  output logic [INT_AW-1:0] int_addr,
  output logic [OVL_W-1:0]  int_ovl,
  output logic              int_we,
  output logic              int_re,
  output logic [WORD_W-1:0] int_wdata,
  input  logic [WORD_W-1:0] int_rdata,
  output logic              core_hold,
  output logic              core_restart,
  output logic              done,
  output logic              err
);

  logic              byte_req, byte_active, byte_last;
  logic              dir_store, load_word, shift_byte, ctx_mode;
  logic [WAIT_W-1:0] waits;

  bytepack_dma_ctrl #(
    .EXT_AW(EXT_AW), .INT_AW(INT_AW), .CNT_W(CNT_W),
    .OVL_W(OVL_W), .BYTE_W(BYTE_W), .WORD_W(WORD_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_dir(cfg_dir), .cfg_ext_addr(cfg_ext_addr), .cfg_int_addr(cfg_int_addr),
    .cfg_count(cfg_count), .cfg_waits(cfg_waits), .cfg_ovl(cfg_ovl),
    .cfg_ctx_reset(cfg_ctx_reset), .byte_last(byte_last),
    .byte_req(byte_req), .dir_store(dir_store), .waits(waits),
    .load_word(load_word), .shift_byte(shift_byte),
    .ext_addr(ext_addr), .int_addr(int_addr), .int_ovl(int_ovl),
    .int_we(int_we), .int_re(int_re), .ctx_mode(ctx_mode),
    .core_hold(core_hold), .core_restart(core_restart),
    .done(done), .err(err)
  );

  bytepack_dma_extport u_ext (
    .clk(clk), .rst_n(rst_n), .req(byte_req), .core_req(core_ext_req),
    .waits(waits), .active(byte_active), .last(byte_last)
  );

  bytepack_dma_packer #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .load_word(load_word), .shift_byte(shift_byte),
    .word_in(int_rdata), .byte_in(ext_rdata),
    .word_out(int_wdata), .byte_out(ext_wdata)
  );

  assign ext_rd = byte_active && !dir_store;
  assign ext_wr = byte_active && dir_store;

  AST_HOLD_COVERS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_mode && (ext_rd || ext_wr || int_we || int_re)) |-> core_hold); // R7

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ext_rd, ext_wr, int_we, int_re})); // R1

endmodule

// File: tb/bytepack_dma_test.sv
module bytepack_dma_test;

  localparam int CLK_PERIOD = 10;
  localparam int EXT_AW = 14;
  localparam int INT_AW = 10;
  localparam int CNT_W  = 10;
  localparam int OVL_W  = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic              cfg_dir;
  logic [EXT_AW-1:0] cfg_ext_addr;
  logic [INT_AW-1:0] cfg_int_addr;
  logic [CNT_W-1:0]  cfg_count;
  logic [2:0]        cfg_waits;
  logic [OVL_W-1:0]  cfg_ovl;
  logic              cfg_ctx_reset;
  logic              core_ext_req;
  logic [EXT_AW-1:0] ext_addr;
  logic              ext_rd, ext_wr;
  logic [7:0]        ext_wdata, ext_rdata;
  logic [INT_AW-1:0] int_addr;
  logic [OVL_W-1:0]  int_ovl;
  logic              int_we, int_re;
  logic [15:0]       int_wdata, int_rdata;
  logic              core_hold, core_restart, done, err;

  logic [7:0]  emem [0:255];
  logic [15:0] imem [0:(1<<(OVL_W+INT_AW))-1];

  int tests = 0, fails = 0;
  int starts, len_err, arb_err, hold_err, done_cnt, rest_cnt, err_cnt, we_cnt, re_cnt, ovl_err, run;
  int exp_w, exp_ovl;
  bit exp_ctx, prev_strobe, prev_core, arb_mode;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  bytepack_dma uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_dir(cfg_dir),
    .cfg_ext_addr(cfg_ext_addr), .cfg_int_addr(cfg_int_addr), .cfg_count(cfg_count),
    .cfg_waits(cfg_waits), .cfg_ovl(cfg_ovl), .cfg_ctx_reset(cfg_ctx_reset),
    .core_ext_req(core_ext_req), .ext_addr(ext_addr), .ext_rd(ext_rd), .ext_wr(ext_wr),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .int_addr(int_addr), .int_ovl(int_ovl),
    .int_we(int_we), .int_re(int_re), .int_wdata(int_wdata), .int_rdata(int_rdata),
    .core_hold(core_hold), .core_restart(core_restart), .done(done), .err(err)
  );

  // memory models
  assign ext_rdata = emem[ext_addr[7:0]];
  always @(posedge clk) begin
    if (ext_wr) emem[ext_addr[7:0]] <= ext_wdata;
    if (int_we) imem[{int_ovl, int_addr}] <= int_wdata;
    if (int_re) int_rdata <= imem[{int_ovl, int_addr}];
  end

  // core bus contention
  always @(posedge clk) begin
    #1;
    if (arb_mode) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      core_ext_req = (lfsr[1:0] != 2'b00);
    end else begin
      core_ext_req = 1'b0;
    end
  end

  // monitors sampled away from the active edge
  always @(negedge clk) begin
    bit strobe;
    strobe = ext_rd || ext_wr;
    if (strobe && !prev_strobe) begin
      starts++;
      if (prev_core) arb_err++;
    end
    if (strobe) run++;
    else if (run > 0) begin
      if (run != exp_w + 1) len_err++;
      run = 0;
    end
    if (exp_ctx && (strobe || int_we || int_re) && !core_hold) hold_err++;
    if (!exp_ctx && core_hold) hold_err++;
    if ((int_we || int_re) && (int_ovl != OVL_W'(exp_ovl))) ovl_err++;
    if (done) done_cnt++;
    if (core_restart) rest_cnt++;
    if (err) err_cnt++;
    if (int_we) we_cnt++;
    if (int_re) re_cnt++;
    prev_strobe = strobe;
    prev_core = core_ext_req;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_stats();
    starts = 0; len_err = 0; arb_err = 0; hold_err = 0; done_cnt = 0;
    rest_cnt = 0; err_cnt = 0; we_cnt = 0; re_cnt = 0; ovl_err = 0; run = 0;
  endtask

  task automatic drive_start(input bit dir, input int eb, input int ib, input int cnt,
                             input int w, input int ovl, input bit ctx);
    @(posedge clk); #1;
    cfg_dir = dir; cfg_ext_addr = EXT_AW'(eb); cfg_int_addr = INT_AW'(ib);
    cfg_count = CNT_W'(cnt); cfg_waits = 3'(w); cfg_ovl = OVL_W'(ovl);
    cfg_ctx_reset = ctx; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic run_xfer(input bit dir, input int eb, input int ib, input int cnt,
                          input int w, input int ovl, input bit ctx, input bit poke);
    int mism = 0;
    int guard = 0;
    clear_stats();
    exp_w = w; exp_ovl = ovl; exp_ctx = ctx;
    drive_start(dir, eb, ib, cnt, w, ovl, ctx);
    while (done_cnt == 0 && guard < 8000) begin
      @(negedge clk);
      guard++;
      if (poke && guard == 6) drive_start(!dir, 3, 7, 9, 0, 2, !ctx); // R12 ignored start
    end
    repeat (4) @(negedge clk);
    for (int k = 0; k < cnt; k++) begin
      logic [15:0] wrd;
      wrd = imem[{OVL_W'(ovl), INT_AW'(ib + k)}];
      if (wrd[15:8] != emem[8'(eb + 2*k)] || wrd[7:0] != emem[8'(eb + 2*k + 1)]) mism++;
    end
    check(mism == 0, dir ? "R2 store byte order" : "R1 load packing", mism, 0);
    check((dir ? re_cnt : we_cnt) == cnt, dir ? "R2 one read per word" : "R1 one write per word",
          dir ? re_cnt : we_cnt, cnt);
    check((dir ? we_cnt : re_cnt) == 0, "R1 R2 no opposite-direction access",
          dir ? we_cnt : re_cnt, 0);
    check(starts == 2 * cnt, "R3 byte accesses", starts, 2 * cnt);
    check(len_err == 0, "R4 strobe length", len_err, 0);
    check(arb_err == 0, "R5 core priority", arb_err, 0);
    check(hold_err == 0, ctx ? "R7 hold during transfer" : "R6 no hold", hold_err, 0);
    check(rest_cnt == int'(ctx), ctx ? "R7 restart pulse" : "R6 no restart", rest_cnt, int'(ctx));
    check(done_cnt == 1, "R8 single done", done_cnt, 1);
    check(core_hold == 1'b0, "R8 hold released", int'(core_hold), 0);
    check(ovl_err == 0, "R9 overlay page", ovl_err, 0);
    if (poke) check(err_cnt == 0, "R12 busy start ignored", err_cnt, 0);
  endtask

  task automatic illegal_req(input int ovl);
    clear_stats();
    exp_w = 0; exp_ovl = ovl; exp_ctx = 1'b0;
    drive_start(1'b0, 0, 0, 4, 0, ovl, 1'b0);
    repeat (12) @(negedge clk);
    check(err_cnt == 1, "R10 err pulse", err_cnt, 1);
    check(starts + we_cnt + re_cnt == 0, "R10 no access", starts + we_cnt + re_cnt, 0);
    check(done_cnt == 0, "R10 no done", done_cnt, 0);
  endtask

  task automatic zero_count();
    clear_stats();
    exp_w = 0; exp_ovl = 0; exp_ctx = 1'b1;
    drive_start(1'b0, 0, 0, 0, 0, 0, 1'b1);
    repeat (8) @(negedge clk);
    check(done_cnt == 1, "R11 done on zero count", done_cnt, 1);
    check(starts + we_cnt + re_cnt == 0, "R11 no access", starts + we_cnt + re_cnt, 0);
    check(rest_cnt == 1, "R11 R7 restart on zero count", rest_cnt, 1);
  endtask

  task automatic reset_check();
    @(negedge clk);
    check({ext_rd, ext_wr, int_we, int_re} == 4'b0, "R3 idle after reset",
          int'({ext_rd, ext_wr, int_we, int_re}), 0);
    check({core_hold, core_restart, done, err} == 4'b0, "R8 outputs low after reset",
          int'({core_hold, core_restart, done, err}), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) emem[i] = 8'(i * 37 + 5);
    for (int i = 0; i < (1 << (OVL_W + INT_AW)); i++) imem[i] = 16'(i * 4099 + 11);
    rst_n = 1'b0; start = 1'b0; cfg_dir = 1'b0; cfg_ext_addr = '0; cfg_int_addr = '0;
    cfg_count = '0; cfg_waits = '0; cfg_ovl = '0; cfg_ctx_reset = 1'b0;
    core_ext_req = 1'b0; arb_mode = 1'b0; int_rdata = '0;
    prev_strobe = 1'b0; prev_core = 1'b0; exp_ctx = 1'b0; exp_w = 0; exp_ovl = 0;
    clear_stats();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    reset_check();

    run_xfer(1'b0, 16'h10, 16'h20, 4, 0, 0, 1'b0, 1'b0);   // load, no waits
    run_xfer(1'b0, 16'h31, 16'h40, 3, 3, 4, 1'b1, 1'b0);   // load, odd start, ctx
    run_xfer(1'b1, 16'h80, 16'h60, 3, 2, 5, 1'b0, 1'b0);   // store
    run_xfer(1'b1, 16'hA0, 16'h70, 2, 7, 0, 1'b1, 1'b0);   // store, max waits, ctx
    arb_mode = 1'b1;
    run_xfer(1'b0, 16'h50, 16'h90, 5, 1, 3, 1'b0, 1'b0);   // load under contention
    run_xfer(1'b1, 16'hC0, 16'hB0, 3, 0, 6, 1'b1, 1'b0);   // store under contention
    arb_mode = 1'b0;
    repeat (2) @(negedge clk);
    run_xfer(1'b0, 16'hE0, 16'h100, 6, 0, 7, 1'b0, 1'b1);  // start while busy
    illegal_req(1);
    illegal_req(2);
    zero_count();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule